// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block drives the read and write strobes of programmed-I/O cycles on an IDE cable. Every access has two phases: an active phase, in which the strobe is asserted, and a recovery phase, in which the strobe is low and no new access may begin. Both phases are counted in local-bus clock cycles. The lengths come from timing bytes that the host loads through a small register port. Each timing byte has an active field in its low nibble and a recovery field in its high nibble. Both fields are kept inverted, that is, as a base constant minus the cycle count.

There are two build variants. The dual-timer variant has two timing bytes. A control bit decides how they are assigned: either one byte per channel, or one byte per drive when only the primary port is in use. The single-timer variant has one timing byte. Its decode base depends on a bus-speed strap that tells the block whether the local bus runs at 33 MHz or slower. A requester presents the direction, the channel and the drive. It sees `req_ready_o` while the block is idle, and it sees a one-cycle `req_done_o` in the final cycle of the strobe.

Top module: `pio_strobe_gen`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. From the next cycle the block raises `wr_strobe_o` if `req_write_i` was 1, or `rd_strobe_o` if it was 0, never both. `req_done_o` is high only in the last strobe cycle. `req_ready_o` is high only when no active or recovery phase is running.
- R2: In the dual-timer build, the strobe lasts 17 minus bits [3:0] of the selected timing byte, giving 2 to 17 cycles.
- R3: In the dual-timer build, the recovery phase lasts 15 minus bits [7:4] of the selected timing byte, but never less than 2 cycles. Field values 14 and 15 therefore both give 2 cycles.
- R4: In the single-timer build with `bus_slow_i`=1, the strobe lasts 9 minus bits [2:0] of the timing byte (2 to 9 cycles), and recovery lasts 15 minus bits [7:4] (0 to 15 cycles). With 0 cycles, `req_ready_o` returns in the cycle right after the last strobe cycle.
- R5: In the single-timer build with `bus_slow_i`=0, the strobe lasts 8 minus bits [2:0] (1 to 8 cycles), and recovery lasts 18 minus bits [7:4] (3 to 18 cycles).
- R6: In the single-timer build, bit 3 of the timing byte has no effect on either phase. A write to address 2 or 3 has no effect and reads back 0.
- R7: Register addresses are: 0 for timer A, 2 for timer B, 3 for control. Address 1 is read-only and returns `bus_slow_i` in bit 2 and 0 in all other bits. Writes to address 1 are ignored.
- R8: In the dual-timer build, control bit 0 = 1 selects timer A for drive 0 and timer B for drive 1, whatever the channel. Control bit 0 = 0 selects timer A for channel 0 and timer B for channel 1, whatever the drive.
- R9: A request held during recovery is not accepted and starts no strobe until recovery ends. The gap between the two strobes is the recovery count plus one cycle.
- R10: The phase counts are captured when a request is accepted. A timing write made during an access changes only the later accesses.
- R11: After reset the block is idle with both strobes low. Every timing byte holds the slowest encoding: 0x00 in the dual-timer build and 0x08 in the single-timer build. The control register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local-bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_slow_i | input | 1 | Strap: 1 when the bus runs at 33 MHz or slower |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data (combinational) |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_chan_i | input | 1 | Channel of the access |
| req_drive_i | input | 1 | Drive number of the access |
| req_ready_o | output | 1 | Idle, will accept a request |
| req_done_o | output | 1 | Last cycle of the strobe |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |

## Verification
The bench targets the ends of each decode range. It uses field values 14 and 15 in the dual-timer recovery field, where a design without the clamp would give a 1-cycle or 0-cycle recovery. It checks the single-timer recovery of 0, where a design with an extra wait state would hold `req_ready_o` low for one cycle too many, and the fast-strap strobe of one cycle. It swaps channel and drive in both control modes, so a design that decodes the wrong request bit picks the wrong timer and shows the wrong lengths. It also rewrites a timer in mid-strobe, where a design that decodes live would stretch or cut the running access. It holds a request through recovery, where a design that accepts early would shorten the gap between strobes.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

  localparam int unsigned CNT_W  = 5;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_TMR_A = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TMR_B = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd3;

  localparam int unsigned CFG_SLOW_BIT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
  } phase_cnt_t;

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_strobe_pkg::*;
#(
  parameter bit DUAL_TIMER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_slow_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] tmr_a_o,
  output logic [DATA_W-1:0] tmr_b_o,
  output logic              single_port_o
);

  // slowest legal encoding; single-timer keeps its fixed bit 3 set
  localparam logic [DATA_W-1:0] TMR_RST = DUAL_TIMER ? 8'h00 : 8'h08;

  logic [DATA_W-1:0] tmr_a_q;
  logic [DATA_W-1:0] tmr_b_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cfg_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_a_q <= TMR_RST;
    end else if (we_i && addr_i == ADDR_TMR_A) begin
      tmr_a_q <= wdata_i;
    end
  end

  generate
    if (DUAL_TIMER) begin : g_dual
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tmr_b_q <= TMR_RST;
        end else if (we_i && addr_i == ADDR_TMR_B) begin
          tmr_b_q <= wdata_i;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ctrl_q <= '0;
        end else if (we_i && addr_i == ADDR_CTRL) begin
          ctrl_q <= wdata_i;
        end
      end
    end else begin : g_single
      assign tmr_b_q = '0;
      assign ctrl_q  = '0;
    end
  endgenerate

  always_comb begin
    cfg_val               = '0;
    cfg_val[CFG_SLOW_BIT] = bus_slow_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_TMR_A: rdata_o = tmr_a_q;
      ADDR_CFG:   rdata_o = cfg_val;
      ADDR_TMR_B: rdata_o = tmr_b_q;
      default:    rdata_o = ctrl_q;
    endcase
  end

  assign tmr_a_o       = tmr_a_q;
  assign tmr_b_o       = tmr_b_q;
  assign single_port_o = ctrl_q[0];

endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_strobe_pkg::*;
#(
  parameter bit DUAL_TIMER = 1'b1
) (
  input  logic [DATA_W-1:0] tmr_i,
  input  logic              bus_slow_i,
  output phase_cnt_t        cnt_o
);

  localparam logic [CNT_W-1:0] DUAL_ACT_BASE = CNT_W'(17);
  localparam logic [CNT_W-1:0] DUAL_REC_BASE = CNT_W'(15);
  localparam logic [CNT_W-1:0] DUAL_REC_MIN  = CNT_W'(2);
  localparam logic [CNT_W-1:0] SLOW_ACT_BASE = CNT_W'(9);
  localparam logic [CNT_W-1:0] SLOW_REC_BASE = CNT_W'(15);
  localparam logic [CNT_W-1:0] FAST_ACT_BASE = CNT_W'(8);
  localparam logic [CNT_W-1:0] FAST_REC_BASE = CNT_W'(18);

  logic [CNT_W-1:0] act_fld;
  logic [CNT_W-1:0] rec_fld;

  assign rec_fld = CNT_W'(tmr_i[7:4]);

  generate
    if (DUAL_TIMER) begin : g_dual
      logic [CNT_W-1:0] rec_raw;
      logic             unused_strap;

      assign unused_strap = bus_slow_i;
      assign act_fld      = CNT_W'(tmr_i[3:0]);
      assign rec_raw      = DUAL_REC_BASE - rec_fld;
      assign cnt_o.act    = DUAL_ACT_BASE - act_fld;
      assign cnt_o.rec    = (rec_raw < DUAL_REC_MIN) ? DUAL_REC_MIN : rec_raw;
    end else begin : g_single
      logic unused_fixed_bit;

      // bit 3 is a fixed marker, not part of the active field
      assign unused_fixed_bit = tmr_i[3];
      assign act_fld          = CNT_W'(tmr_i[2:0]);
      assign cnt_o.act = (bus_slow_i ? SLOW_ACT_BASE : FAST_ACT_BASE) - act_fld;
      assign cnt_o.rec = (bus_slow_i ? SLOW_REC_BASE : FAST_REC_BASE) - rec_fld;
    end
  endgenerate

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
  import pio_strobe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       write_i,
  input  phase_cnt_t cnt_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       rd_o,
  output logic       wr_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rec_q;
  logic             wr_q;
  logic             last_cyc;

  assign last_cyc = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            // counts frozen here; later register writes wait for the next access
            state_q <= ST_ACT;
            cnt_q   <= cnt_i.act;
            rec_q   <= cnt_i.rec;
            wr_q    <= write_i;
          end
        end
        ST_ACT: begin
          if (last_cyc) begin
            state_q <= (rec_q == '0) ? ST_IDLE : ST_REC;
            cnt_q   <= rec_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_REC: begin
          if (last_cyc) begin
            state_q <= ST_IDLE;
          end
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = (state_q == ST_ACT) && last_cyc;
  assign rd_o    = (state_q == ST_ACT) && !wr_q;
  assign wr_o    = (state_q == ST_ACT) && wr_q;

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter bit DUAL_TIMER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_slow_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_chan_i,
  input  logic              req_drive_i,
  output logic              req_ready_o,
  output logic              req_done_o,
  output logic              rd_strobe_o,
  output logic              wr_strobe_o
);

  logic [DATA_W-1:0] tmr_a;
  logic [DATA_W-1:0] tmr_b;
  logic [DATA_W-1:0] tmr_sel;
  logic              single_port;
  logic              use_b;
  phase_cnt_t        cnt;

  pio_timing_regs #(
    .DUAL_TIMER(DUAL_TIMER)
  ) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_slow_i   (bus_slow_i),
    .we_i         (cfg_we_i),
    .addr_i       (cfg_addr_i),
    .wdata_i      (cfg_wdata_i),
    .rdata_o      (cfg_rdata_o),
    .tmr_a_o      (tmr_a),
    .tmr_b_o      (tmr_b),
    .single_port_o(single_port)
  );

  // primary-only mode maps timers per drive, otherwise per channel
  assign use_b   = DUAL_TIMER && (single_port ? req_drive_i : req_chan_i);
  assign tmr_sel = use_b ? tmr_b : tmr_a;

  pio_timing_decode #(
    .DUAL_TIMER(DUAL_TIMER)
  ) i_decode (
    .tmr_i     (tmr_sel),
    .bus_slow_i(bus_slow_i),
    .cnt_o     (cnt)
  );

  pio_strobe_seq i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_valid_i),
    .write_i(req_write_i),
    .cnt_i  (cnt),
    .ready_o(req_ready_o),
    .done_o (req_done_o),
    .rd_o   (rd_strobe_o),
    .wr_o   (wr_strobe_o)
  );

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk #(
  parameter bit DUAL_TIMER = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic req_done_o,
  input logic rd_strobe_o,
  input logic wr_strobe_o
);

  logic       strobe;
  logic [5:0] run_q;

  assign strobe = rd_strobe_o | wr_strobe_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (strobe) begin
      run_q <= run_q + 6'd1;
    end else begin
      run_q <= '0;
    end
  end

  // R1
  a_r1_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_o && wr_strobe_o));

  // R1
  a_r1_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> !req_ready_o);

  // R1
  a_r1_done_ends_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !strobe);

  // R1
  a_r1_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && $past(strobe)) |-> $stable(wr_strobe_o));

  // R9
  a_r9_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe) |-> $past(req_ready_o));

  // R3
  a_r3_rec_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DUAL_TIMER && $fell(strobe)) |=> !req_ready_o);

  // R2
  a_r2_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> (run_q < 6'd18));

endmodule

bind pio_strobe_gen pio_strobe_gen_chk #(
  .DUAL_TIMER(DUAL_TIMER)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .req_done_o (req_done_o),
  .rd_strobe_o(rd_strobe_o),
  .wr_strobe_o(wr_strobe_o)
);

// File: tb/test_pio_strobe_gen.sv
module test_pio_strobe_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;  // 0: dual-timer DUT, 1: single-timer DUT
  logic       bus_slow = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       req = 1'b0;
  logic       req_wr = 1'b0;
  logic       req_ch = 1'b0;
  logic       req_dr = 1'b0;

  logic [7:0] d_rdata, s_rdata;
  logic d_ready, d_done, d_rd, d_wr;
  logic s_ready, s_done, s_rd, s_wr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pio_strobe_gen #(.DUAL_TIMER(1'b1)) i_pio_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .bus_slow_i(bus_slow),
    .cfg_we_i(we && !sel), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(d_rdata),
    .req_valid_i(req && !sel), .req_write_i(req_wr),
    .req_chan_i(req_ch), .req_drive_i(req_dr),
    .req_ready_o(d_ready), .req_done_o(d_done),
    .rd_strobe_o(d_rd), .wr_strobe_o(d_wr)
  );

  pio_strobe_gen #(.DUAL_TIMER(1'b0)) i_pio_strobe_gen_single (
    .clk_i(clk), .rst_ni(rst_n), .bus_slow_i(bus_slow),
    .cfg_we_i(we && sel), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(s_rdata),
    .req_valid_i(req && sel), .req_write_i(req_wr),
    .req_chan_i(req_ch), .req_drive_i(req_dr),
    .req_ready_o(s_ready), .req_done_o(s_done),
    .rd_strobe_o(s_rd), .wr_strobe_o(s_wr)
  );

  wire [7:0] rdata = sel ? s_rdata : d_rdata;
  wire       ready = sel ? s_ready : d_ready;
  wire       done  = sel ? s_done  : d_done;
  wire       rd_s  = sel ? s_rd    : d_rd;
  wire       wr_s  = sel ? s_wr    : d_wr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected lengths, straight from the requirements
  function automatic int d_act(input logic [7:0] b); return 17 - b[3:0]; endfunction
  function automatic int d_rec(input logic [7:0] b);
    int r = 15 - b[7:4];
    return (r < 2) ? 2 : r;
  endfunction
  function automatic int s_act(input logic [7:0] b, input bit slow);
    return (slow ? 9 : 8) - b[2:0];
  endfunction
  function automatic int s_rec(input logic [7:0] b, input bit slow);
    return (slow ? 15 : 18) - b[7:4];
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  // one access; optional register write during the first strobe cycle
  task automatic access(input bit w, input bit ch, input bit dr,
                        input int exp_act, input int exp_rec, input string tag,
                        input bit mid = 1'b0, input logic [1:0] maddr = '0,
                        input logic [7:0] mdata = '0);
    int n = 0, m = 0, done_at = -1, done_cnt = 0, guard = 0;
    bit dir_ok = 1'b1;
    @(negedge clk);
    req_wr = w; req_ch = ch; req_dr = dr; req = 1'b1;
    while (!ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    req = 1'b0;
    while ((rd_s || wr_s) && n < 40) begin
      if (wr_s != w || rd_s != !w) dir_ok = 1'b0;
      if (done) begin done_at = n; done_cnt++; end
      if (mid && n == 0) begin we = 1'b1; addr = maddr; wdata = mdata; end
      if (n == 1) we = 1'b0;
      n++;
      @(negedge clk);
    end
    we = 1'b0;
    while (!ready && m < 40) begin
      if (rd_s || wr_s) dir_ok = 1'b0;
      m++;
      @(negedge clk);
    end
    chk(n == exp_act, {tag, " strobe length"}, n, exp_act);
    chk(m == exp_rec, {tag, " recovery length"}, m, exp_rec);
    chk(dir_ok && done_cnt == 1 && done_at == n - 1, {"R1 ", tag, " direction/done"},
        done_at, n - 1);
  endtask

  task automatic t_reset();
    sel = 1'b0;
    chk(d_ready && !d_rd && !d_wr && !d_done, "R11 dual idle after reset", d_ready, 1);
    chk(s_ready && !s_rd && !s_wr && !s_done, "R11 single idle after reset", s_ready, 1);
    rd_chk(2'd0, 8'h00, "R11 dual timer A reset");
    rd_chk(2'd2, 8'h00, "R11 dual timer B reset");
    rd_chk(2'd3, 8'h00, "R11 dual control reset");
    sel = 1'b1;
    rd_chk(2'd0, 8'h08, "R11 single timer A reset");
    sel = 1'b0;
    access(1'b0, 1'b0, 1'b0, 17, 15, "R11 dual reset timing");
    sel = 1'b1; bus_slow = 1'b1;
    access(1'b1, 1'b0, 1'b0, 9, 15, "R11 single reset timing");
    sel = 1'b0;
  endtask

  task automatic t_dual_decode();
    logic [7:0] v [4] = '{8'h5A, 8'hFF, 8'hE0, 8'hD3};
    sel = 1'b0;
    foreach (v[i]) begin
      wr_reg(2'd0, v[i]);
      access(i[0], 1'b0, 1'b0, d_act(v[i]), d_rec(v[i]), "R2 R3 dual decode");
    end
    bus_slow = 1'b1;
    rd_chk(2'd1, 8'h04, "R7 config strap slow");
    wr_reg(2'd1, 8'hFF);
    bus_slow = 1'b0;
    rd_chk(2'd1, 8'h00, "R7 config strap fast, write ignored");
    bus_slow = 1'b1;
  endtask

  task automatic t_dual_map();
    sel = 1'b0;
    wr_reg(2'd0, 8'h3C);
    wr_reg(2'd2, 8'h96);
    wr_reg(2'd3, 8'h00);
    access(1'b0, 1'b0, 1'b1, d_act(8'h3C), d_rec(8'h3C), "R8 chan mode ch0 dr1");
    access(1'b1, 1'b1, 1'b0, d_act(8'h96), d_rec(8'h96), "R8 chan mode ch1 dr0");
    wr_reg(2'd3, 8'h01);
    rd_chk(2'd3, 8'h01, "R7 control readback");
    access(1'b1, 1'b0, 1'b1, d_act(8'h96), d_rec(8'h96), "R8 drive mode ch0 dr1");
    access(1'b0, 1'b1, 1'b0, d_act(8'h3C), d_rec(8'h3C), "R8 drive mode ch1 dr0");
    wr_reg(2'd3, 8'h00);
  endtask

  task automatic t_single();
    sel = 1'b1; bus_slow = 1'b1;
    wr_reg(2'd0, 8'h28);
    access(1'b0, 1'b1, 1'b1, s_act(8'h28, 1), s_rec(8'h28, 1), "R4 slow longest act");
    wr_reg(2'd0, 8'hFF);
    access(1'b1, 1'b0, 1'b0, s_act(8'hFF, 1), s_rec(8'hFF, 1), "R4 slow zero recovery");
    wr_reg(2'd0, 8'h4B);
    access(1'b0, 1'b0, 1'b0, 6, 11, "R6 bit3 set");
    wr_reg(2'd0, 8'h43);
    access(1'b0, 1'b0, 1'b0, 6, 11, "R6 bit3 clear");
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd3, 8'h01);
    rd_chk(2'd2, 8'h00, "R6 single timer B absent");
    rd_chk(2'd3, 8'h00, "R6 single control absent");
    access(1'b0, 1'b1, 1'b1, 6, 11, "R6 single ignores chan/drive");
    rd_chk(2'd1, 8'h04, "R7 single config strap");
    bus_slow = 1'b0;
    wr_reg(2'd0, 8'h08);
    access(1'b1, 1'b0, 1'b0, s_act(8'h08, 0), s_rec(8'h08, 0), "R5 fast longest");
    wr_reg(2'd0, 8'hFF);
    access(1'b0, 1'b0, 1'b0, s_act(8'hFF, 0), s_rec(8'hFF, 0), "R5 fast shortest");
    bus_slow = 1'b1;
    sel = 1'b0;
  endtask

  task automatic t_hold_in_recovery();
    int gap = 0, guard = 0;
    sel = 1'b0;
    wr_reg(2'd0, 8'h5A);  // act 7, rec 10
    @(negedge clk);
    req_wr = 1'b0; req_ch = 1'b0; req_dr = 1'b0; req = 1'b1;
    while (!(rd_s || wr_s) && guard < 60) begin @(negedge clk); guard++; end
    while ((rd_s || wr_s) && guard < 120) begin @(negedge clk); guard++; end
    while (!(rd_s || wr_s) && gap < 60) begin @(negedge clk); gap++; end
    chk(gap == 11, "R9 held request waits for recovery", gap, 11);
    req = 1'b0;
    guard = 0;
    while (!ready && guard < 60) begin @(negedge clk); guard++; end
  endtask

  task automatic t_mid_write();
    sel = 1'b0;
    wr_reg(2'd0, 8'h5A);
    access(1'b1, 1'b0, 1'b0, 7, 10, "R10 running access unchanged", 1'b1, 2'd0, 8'hFF);
    rd_chk(2'd0, 8'hFF, "R10 mid-access write stored");
    access(1'b0, 1'b0, 1'b0, 2, 2, "R10 next access uses new byte");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dual_decode();
    t_dual_map();
    t_single();
    t_hold_in_recovery();
    t_mid_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule